// File: doc/BRIEF.md
# Secondary Interrupt Controller with Pass-Through

This block collects 32 level-sensitive interrupt sources and presents them to a primary vectored interrupt controller. It tracks the current level of every source, gates the levels with a software-controlled enable mask and raises one combined request when any enabled source is active. That combined request drives the top output line.

For a fixed band of sources, lines 21 to 30, software can also route a source around the aggregation. The source then drives its own upstream line directly, so the primary controller can vector it on its own.

Software reaches the block through a simple word-addressed register bus. The enable mask and the pass-through enables are never written whole. Separate registers set or clear chosen bits, and a pair of soft registers acts on enable bit 0 alone.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset the raw level, enable mask and pass-through enable registers read zero, and all 32 output lines are low.
- R2: The raw level register captures `irq_i` on every clock, bit i holding source i. It reads at byte offset 0x04.
- R3: Output line 31 goes high exactly when (raw AND enable) is nonzero. It follows its inputs one clock after the registers holding them change.
- R4: Offset 0x00 reads raw AND enable. Offset 0x08 reads the enable mask.
- R5: A write to 0x08 ORs the write data into the enable mask.
- R6: A write to 0x0C clears every enable bit where the write data is 1.
- R7: A read of 0x10 returns raw bit 0 in bit 0, with every other bit zero. A write to 0x10 with nonzero data sets enable bit 0. A write of zero there changes nothing.
- R8: A write to 0x14 with nonzero data clears enable bit 0. A write of zero there changes nothing.
- R9: A write to 0x20 ORs (data AND 0x7FE00000) into the pass-through enable register, so only bits 21 to 30 can be set. The register reads at 0x20.
- R10: A write to 0x24 clears every pass-through bit where the write data is 1.
- R11: For each line i in 21..30 whose pass-through bit is set, output i takes raw bit i one clock later. This also refreshes the line right after its bit is set. While the bit is clear, the line holds its last value.
- R12: Output lines 0 to 20 are always low.
- R13: An access to any other offset has no effect, and a read of one returns zero. Other offsets include 0x0C, 0x14, 0x24, a misaligned address (address bits 1:0 nonzero) and any address at or above 0x40.
- R14: Read data is registered and appears on the cycle after the read strobe. In every cycle that follows no read strobe, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level-sensitive interrupt sources, synchronous to clk_i |
| bus_valid_i | input | 1 | Single-cycle access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 12 | Byte address within the 4 KB window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 32 | Upstream lines: 31 combined, 21..30 pass-through, rest low |

## Verification
A source level change and an enable-mask write can land in the same clock. In that case the combined line must reflect both at once and show no one-cycle glitch. The bench provokes this in two ways. In one cycle it raises source 8 while clearing its enable bit, and checks that line 31 stays low. In another cycle it raises source 9 while setting its enable bit, and checks that line 31 rises exactly one clock later. A similar overlap arises on the pass-through lines, where an enable change and a level change meet. There the bench checks the hold value and the refresh at the exact clock after each register update.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;
  localparam logic [3:0] W_MSTAT    = 4'h0;
  localparam logic [3:0] W_RAW      = 4'h1;
  localparam logic [3:0] W_EN_SET   = 4'h2;
  localparam logic [3:0] W_EN_CLR   = 4'h3;
  localparam logic [3:0] W_SOFT_SET = 4'h4;
  localparam logic [3:0] W_SOFT_CLR = 4'h5;
  localparam logic [3:0] W_PT_SET   = 4'h8;
  localparam logic [3:0] W_PT_CLR   = 4'h9;

  typedef enum logic [2:0] {
    RD_NONE, RD_MSTAT, RD_RAW, RD_EN, RD_SOFT, RD_PT
  } rd_sel_e;

  typedef struct packed {
    logic en_or;
    logic en_andn;
    logic soft_set;
    logic soft_clr;
    logic pt_or;
    logic pt_andn;
  } wr_op_t;

  function automatic logic [63:0] span_mask(input int lo, input int hi);
    logic [63:0] m;
    for (int b = 0; b < 64; b++) m[b] = (b >= lo) && (b <= hi);
    return m;
  endfunction
endpackage

// File: rtl/sec_irq_decode.sv
module sec_irq_decode
  import sec_irq_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output wr_op_t        op_o,
  output rd_sel_e       rsel_o
);
  localparam int unsigned WW = AW - 2;

  logic [WW-1:0] word;
  logic          hit;

  assign word = addr_i[AW-1:2];
  // exact word match only: misaligned or high addresses fall through
  assign hit  = valid_i && (addr_i[1:0] == 2'b00) && (word[WW-1:4] == '0);

  always_comb begin
    op_o   = '0;
    rsel_o = RD_NONE;
    if (hit) begin
      if (we_i) begin
        case (word[3:0])
          W_EN_SET:   op_o.en_or    = 1'b1;
          W_EN_CLR:   op_o.en_andn  = 1'b1;
          W_SOFT_SET: op_o.soft_set = 1'b1;
          W_SOFT_CLR: op_o.soft_clr = 1'b1;
          W_PT_SET:   op_o.pt_or    = 1'b1;
          W_PT_CLR:   op_o.pt_andn  = 1'b1;
          default: ;
        endcase
      end else begin
        case (word[3:0])
          W_MSTAT:    rsel_o = RD_MSTAT;
          W_RAW:      rsel_o = RD_RAW;
          W_EN_SET:   rsel_o = RD_EN;
          W_SOFT_SET: rsel_o = RD_SOFT;
          W_PT_SET:   rsel_o = RD_PT;
          default:    rsel_o = RD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sec_irq_regs.sv
module sec_irq_regs
  import sec_irq_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  wr_op_t          op_i,
  input  rd_sel_e         rsel_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] raw_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] pt_o,
  output logic [NSRC-1:0] rdata_o
);
  localparam logic [NSRC-1:0] PT_MASK = NSRC'(span_mask(PT_LO, PT_HI));

  logic [NSRC-1:0] raw_q, en_q, pt_q, rdata_q;
  logic [NSRC-1:0] en_d, pt_d, rd_d;
  logic            wnz;

  assign wnz = |wdata_i;

  always_comb begin
    en_d = en_q;
    if (op_i.en_or)           en_d = en_d | wdata_i;
    if (op_i.en_andn)         en_d = en_d & ~wdata_i;
    if (op_i.soft_set && wnz) en_d[0] = 1'b1;
    if (op_i.soft_clr && wnz) en_d[0] = 1'b0;
  end

  always_comb begin
    pt_d = pt_q;
    if (op_i.pt_or)   pt_d = pt_d | (wdata_i & PT_MASK);
    if (op_i.pt_andn) pt_d = pt_d & ~wdata_i;
  end

  always_comb begin
    case (rsel_i)
      RD_MSTAT: rd_d = raw_q & en_q;
      RD_RAW:   rd_d = raw_q;
      RD_EN:    rd_d = en_q;
      RD_SOFT:  rd_d = {{(NSRC-1){1'b0}}, raw_q[0]};
      RD_PT:    rd_d = pt_q;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q   <= '0;
      en_q    <= '0;
      pt_q    <= '0;
      rdata_q <= '0;
    end else begin
      raw_q   <= irq_i;
      en_q    <= en_d;
      pt_q    <= pt_d;
      rdata_q <= rd_d;
    end
  end

  assign raw_o   = raw_q;
  assign en_o    = en_q;
  assign pt_o    = pt_q;
  assign rdata_o = rdata_q;

  p_en_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.en_or |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  p_en_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.en_andn |=> ((en_q & $past(wdata_i)) == '0));
  p_soft_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.soft_set && wnz) |=> en_q[0]);
  p_soft_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.soft_clr && wnz) |=> !en_q[0]);
  p_pt_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.pt_andn |=> ((pt_q & $past(wdata_i)) == '0));
  p_rd_idle_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_i == RD_NONE) |=> (rdata_q == '0));
endmodule

// File: rtl/sec_irq_route.sv
module sec_irq_route #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30,
  localparam int unsigned PT_W = PT_HI - PT_LO + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [PT_W-1:0] pt_i,
  output logic [NSRC-1:0] irq_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_line
    if (i == NSRC - 1) begin : g_comb
      logic line_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= 1'b0;
        else         line_q <= |(raw_i & en_i);
      end
      assign irq_o[i] = line_q;

      p_comb_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(raw_i & en_i)) |=> irq_o[i]);
      p_comb_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(raw_i & en_i)) |=> !irq_o[i]);
    end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
      logic line_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             line_q <= 1'b0;
        else if (pt_i[i-PT_LO])  line_q <= raw_i[i];
      end
      assign irq_o[i] = line_q;

      p_pt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(pt_i[i-PT_LO]) |-> $stable(irq_o[i]));
      p_pt_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pt_i[i-PT_LO] |=> (irq_o[i] == $past(raw_i[i])));
    end else begin : g_tie
      assign irq_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sec_irq_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned AW    = 12,
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  logic            bus_valid_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [NSRC-1:0] bus_wdata_i,
  output logic [NSRC-1:0] bus_rdata_o,
  output logic [NSRC-1:0] irq_o
);
  localparam int unsigned PT_W = PT_HI - PT_LO + 1;

  wr_op_t          op;
  rd_sel_e         rsel;
  logic [NSRC-1:0] raw, en, pt;

  sec_irq_decode #(.AW(AW)) u_dec (
    .valid_i (bus_valid_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .op_o    (op),
    .rsel_o  (rsel)
  );

  sec_irq_regs #(.NSRC(NSRC), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .op_i    (op),
    .rsel_i  (rsel),
    .wdata_i (bus_wdata_i),
    .raw_o   (raw),
    .en_o    (en),
    .pt_o    (pt),
    .rdata_o (bus_rdata_o)
  );

  sec_irq_route #(.NSRC(NSRC), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .en_i   (en),
    .pt_i   (pt[PT_HI:PT_LO]),
    .irq_o  (irq_o)
  );

  p_no_low_pt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt[PT_LO-1:0] == '0) && (pt[NSRC-1:PT_HI+1] == '0));
  p_low_lines_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[PT_LO-1:0] == '0);

  if (PT_W < 1) begin : g_bad_cfg
    initial $error("pass-through span empty");
  end
endmodule

// File: tb/sec_irq_ctrl_tb.sv
module sec_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] irq_out;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sec_irq_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_i       (irq),
    .bus_valid_i (valid),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq_out)
  );

  typedef struct packed {
    logic [31:0] irq;
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{32'h0,  1'b0, 12'h004, 32'h0,        32'h0,        8'd1},  // R1
    '{32'h0,  1'b0, 12'h008, 32'h0,        32'h0,        8'd1},  // R1
    '{32'h0,  1'b0, 12'h020, 32'h0,        32'h0,        8'd1},  // R1
    '{32'h0,  1'b0, 12'h000, 32'h0,        32'h0,        8'd1},  // R1
    '{32'hF1, 1'b0, 12'h004, 32'h0,        32'hF1,       8'd2},  // R2
    '{32'hF1, 1'b1, 12'h008, 32'h30,       32'h0,        8'd5},  // R5
    '{32'hF1, 1'b1, 12'h008, 32'h101,      32'h0,        8'd5},  // R5
    '{32'hF1, 1'b0, 12'h008, 32'h0,        32'h131,      8'd5},  // R5
    '{32'hF1, 1'b0, 12'h000, 32'h0,        32'h31,       8'd4},  // R4
    '{32'hF1, 1'b1, 12'h00C, 32'h21,       32'h0,        8'd6},  // R6
    '{32'hF1, 1'b0, 12'h008, 32'h0,        32'h110,      8'd6},  // R6
    '{32'hF1, 1'b0, 12'h000, 32'h0,        32'h10,       8'd4},  // R4
    '{32'hF1, 1'b0, 12'h010, 32'h0,        32'h1,        8'd7},  // R7
    '{32'hF1, 1'b1, 12'h010, 32'h0,        32'h0,        8'd7},  // R7
    '{32'hF1, 1'b0, 12'h008, 32'h0,        32'h110,      8'd7},  // R7
    '{32'hF1, 1'b1, 12'h010, 32'h80,       32'h0,        8'd7},  // R7
    '{32'hF1, 1'b0, 12'h008, 32'h0,        32'h111,      8'd7},  // R7
    '{32'hF1, 1'b1, 12'h014, 32'h0,        32'h0,        8'd8},  // R8
    '{32'hF1, 1'b0, 12'h008, 32'h0,        32'h111,      8'd8},  // R8
    '{32'hF1, 1'b1, 12'h014, 32'h4,        32'h0,        8'd8},  // R8
    '{32'hF1, 1'b0, 12'h008, 32'h0,        32'h110,      8'd8},  // R8
    '{32'hF1, 1'b1, 12'h020, 32'hFFFFFFFF, 32'h0,        8'd9},  // R9
    '{32'hF1, 1'b0, 12'h020, 32'h0,        32'h7FE00000, 8'd9},  // R9
    '{32'hF1, 1'b1, 12'h024, 32'h00600000, 32'h0,        8'd10}, // R10
    '{32'hF1, 1'b0, 12'h020, 32'h0,        32'h7F800000, 8'd10}, // R10
    '{32'hF1, 1'b1, 12'h018, 32'hFFFFFFFF, 32'h0,        8'd13}, // R13
    '{32'hF1, 1'b1, 12'h009, 32'hFFFFFFFF, 32'h0,        8'd13}, // R13 misaligned
    '{32'hF1, 1'b0, 12'h008, 32'h0,        32'h110,      8'd13}, // R13
    '{32'hF1, 1'b0, 12'h020, 32'h0,        32'h7F800000, 8'd13}, // R13
    '{32'hF1, 1'b0, 12'h018, 32'h0,        32'h0,        8'd13}, // R13
    '{32'hF1, 1'b0, 12'h00C, 32'h0,        32'h0,        8'd13}, // R13
    '{32'hF1, 1'b0, 12'h408, 32'h0,        32'h0,        8'd13}, // R13 high
    '{32'h2,  1'b0, 12'h010, 32'h0,        32'h0,        8'd7},  // R7
    '{32'h2,  1'b0, 12'h004, 32'h0,        32'h2,        8'd2}   // R2
  };

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick();
    valid = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    valid = 1'b1; we = 1'b0; addr = a;
    tick();
    valid = 1'b0;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 lines in reset", irq_out, 32'h0);
    chk("R1 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < NV; v++) begin
      irq = VECS[v].irq;
      tick();
      if (VECS[v].we) wr(VECS[v].addr, VECS[v].data);
      else rd(VECS[v].addr, VECS[v].exp, $sformatf("R%0d vec%0d", VECS[v].req, v));
    end

    // en=0x110, pass-through bits 23..30
    irq = 32'h0;
    tick(3);
    chk("R3 combined idle", 32'(irq_out[31]), 32'h0);
    irq = 32'h10;
    tick();
    chk("R3 not yet", 32'(irq_out[31]), 32'h0);
    tick();
    chk("R3 rise", 32'(irq_out[31]), 32'h1);
    wr(12'h00C, 32'h10);
    chk("R3 before mask drop", 32'(irq_out[31]), 32'h1);
    tick();
    chk("R3 after mask drop", 32'(irq_out[31]), 32'h0);

    // same cycle: source 8 rises while its enable is cleared
    irq = 32'h110;
    wr(12'h00C, 32'h100);
    for (int k = 0; k < 3; k++) begin
      chk("R3 collide clear", 32'(irq_out[31]), 32'h0);
      tick();
    end
    // same cycle: source 9 rises while its enable is set
    irq = 32'h310;
    wr(12'h008, 32'h200);
    chk("R3 collide set early", 32'(irq_out[31]), 32'h0);
    tick();
    chk("R3 collide set", 32'(irq_out[31]), 32'h1);

    // pass-through
    irq = (32'h1 << 25) | (32'h1 << 22);
    tick(2);
    chk("R11 line25 follows", 32'(irq_out[25]), 32'h1);
    chk("R11 line22 disabled", 32'(irq_out[22]), 32'h0);
    chk("R11 line24 low", 32'(irq_out[24]), 32'h0);
    wr(12'h024, 32'h1 << 25);
    irq = 32'h1 << 22;
    tick(3);
    chk("R11 line25 holds", 32'(irq_out[25]), 32'h1);
    wr(12'h020, 32'h1 << 25);
    chk("R11 refresh pending", 32'(irq_out[25]), 32'h1);
    tick();
    chk("R11 refresh", 32'(irq_out[25]), 32'h0);

    // low lines stay low
    wr(12'h008, 32'hFFFFFFFF);
    irq = 32'hFFFFFFFF;
    tick(3);
    chk("R12 lines 0..20", {11'h0, irq_out[20:0]}, 32'h0);
    chk("R3 all on", 32'(irq_out[31]), 32'h1);

    // read data timing
    rd(12'h008, 32'hFFFFFFFF, "R14 read en");
    tick();
    chk("R14 idle zero", rdata, 32'h0);
    wr(12'h018, 32'h5);
    chk("R14 write zero", rdata, 32'h0);

    // reset mid-run
    rst_n = 1'b0;
    tick();
    chk("R1 lines after reset", irq_out, 32'h0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 lines stay low", irq_out, 32'h0);
    rd(12'h008, 32'h0, "R1 en cleared");
    rd(12'h020, 32'h0, "R1 pt cleared");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule